// File: doc/BRIEF.md
# Split-Bank Activation Timing Checker

This block observes the stream of decoded row and column commands sent to a 32-bank memory device. In this device neighbouring banks share sense amplifiers. It keeps an open/closed view of every bank and measures the intervals between commands in clock cycles. A command that breaks an adjacency rule or a row-timing rule raises a one-cycle flag, with a separate flag for each rule. A precharge sent to a bank that is already closed raises a warning flag instead of a violation.

Each bank is modelled by a small state machine with two states, `BANK_IDLE` and `BANK_ACTIVE`. An activate moves `BANK_IDLE` to `BANK_ACTIVE`. An activate in `BANK_ACTIVE` stays in `BANK_ACTIVE` and restarts the activate timer. A precharge in `BANK_ACTIVE` returns the bank to `BANK_IDLE`. A precharge in `BANK_IDLE` leaves the state unchanged. Each bank owns two saturating elapsed-cycle counters, one for its last activate and one for its last effective precharge. Two more counters measure spacing across the whole device. Sense-amplifier sharing is modelled as a neighbour map. Banks 0, 15, 16 and 31 have no partner on their outer side, and the pair 15/16 are not neighbours.

Every command is evaluated in the cycle it is presented, and the flags appear on the following cycle. A command always takes effect on the tracked state, even when it raises a flag.

Top module: `sbt_bank_guard`

## Requirements
- R1: After reset every flag is low, every bank is closed, and every timer counts as satisfied. The first activate to any bank after reset raises no flag.
- R2: The command encoding on `cmd_kind` is 0 none, 1 activate, 2 precharge, 3 column access. An activate to bank b raises `err_adjacent` when bank b-1 or bank b+1 is open. Two banks are neighbours only when their numbers differ by one and both lie in the same half (0..15 or 16..31).
- R3: An activate to a bank less than 28 cycles after the previous activate to that same bank raises `err_act_act_bank`.
- R4: A precharge to an open bank less than 20 cycles after its activate raises `err_act_pre`.
- R5: An activate to a closed bank less than 8 cycles after the precharge that closed it raises `err_pre_act`.
- R6: An activate less than 8 cycles after any activate to any bank raises `err_act_act_dev`.
- R7: A precharge less than 8 cycles after any precharge to any bank raises `err_pre_pre_dev`. A precharge to a closed bank also counts toward this spacing.
- R8: A column access to an open bank less than 9 cycles after its activate raises `err_act_col`.
- R9: A precharge to a closed bank raises only `err_idle_pre`. It does not restart that bank's precharge timer, and the bank stays closed.
- R10: All elapsed counters saturate, so an arbitrarily long idle gap never produces a flag.
- R11: The interval between two commands is the difference of the cycles in which they are presented. Each flag is a one-cycle pulse in the cycle after its command. A cycle with `cmd_valid` low has no effect on state or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 2 | 0 none, 1 activate, 2 precharge, 3 column access |
| cmd_bank | input | 5 | Target bank number |
| err_adjacent | output | 1 | Activate while a neighbour bank is open |
| err_act_act_bank | output | 1 | Same-bank activate spacing too short |
| err_act_pre | output | 1 | Activate-to-precharge time too short |
| err_pre_act | output | 1 | Precharge-to-activate time too short |
| err_act_act_dev | output | 1 | Device-wide activate spacing too short |
| err_pre_pre_dev | output | 1 | Device-wide precharge spacing too short |
| err_act_col | output | 1 | Column access too soon after activate |
| err_idle_pre | output | 1 | Warning: precharge to a closed bank |

## Verification
The interesting overlap is an activate that is early on the device-wide spacing and also lands next to an open bank. The bench provokes this by opening bank 9 and activating bank 8 three cycles later, and it requires `err_adjacent` and `err_act_act_dev` to rise in the same cycle. A same-bank re-activate inside 8 cycles must likewise raise both the per-bank and device activate flags together. Each interval sweep steps the gap one cycle at a time across its limit. The expected flag vector is computed from the gap and the limit, and the adjacency sweep covers both neighbours of all 32 banks.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_PRE  = 2'd2,
        CMD_COL  = 2'd3
    } cmd_kind_e;

    typedef enum logic {
        BANK_IDLE   = 1'b0,
        BANK_ACTIVE = 1'b1
    } bank_state_e;

    typedef struct packed {
        logic adjacent;
        logic act_act_bank;
        logic act_pre;
        logic pre_act;
        logic act_act_dev;
        logic pre_pre_dev;
        logic act_col;
        logic idle_pre;
    } flag_set_t;

endpackage

// File: rtl/sbt_elapsed.sv
module sbt_elapsed #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CNT_MAX;
        end else if (restart) begin
            count <= CNT_ONE;
        end else if (count != CNT_MAX) begin
            count <= count + CNT_ONE;
        end
    end

    // R11
    restart_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == CNT_ONE));

    // R10
    saturate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !restart) |=> (count == CNT_MAX));

endmodule

// File: rtl/sbt_bank_slot.sv
module sbt_bank_slot
    import sbt_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_hit,
    input  logic             pre_hit,
    output logic             is_open,
    output logic [CNT_W-1:0] since_act,
    output logic [CNT_W-1:0] since_pre
);
    bank_state_e state_q, state_d;
    logic        close_now;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BANK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_IDLE: begin
                if (act_hit) state_d = BANK_ACTIVE;
            end
            BANK_ACTIVE: begin
                if (pre_hit && !act_hit) state_d = BANK_IDLE;
            end
            default: state_d = BANK_IDLE;
        endcase
    end

    assign is_open   = (state_q == BANK_ACTIVE);
    assign close_now = pre_hit && (state_q == BANK_ACTIVE);

    sbt_elapsed #(.CNT_W(CNT_W)) u_act_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (act_hit),
        .count   (since_act)
    );

    sbt_elapsed #(.CNT_W(CNT_W)) u_pre_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (close_now),
        .count   (since_pre)
    );

    // R3
    act_opens_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |=> (is_open && since_act == CNT_W'(1)));

    // R5
    pre_closes_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && is_open && !act_hit) |=> (!is_open && since_pre == CNT_W'(1)));

    // R9
    idle_pre_keeps_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && !is_open && !act_hit) |=> (!is_open && since_pre != CNT_W'(1)));

endmodule

// File: rtl/sbt_device_pacer.sv
module sbt_device_pacer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_act,
    input  logic             any_pre,
    output logic [CNT_W-1:0] since_any_act,
    output logic [CNT_W-1:0] since_any_pre
);
    sbt_elapsed #(.CNT_W(CNT_W)) u_dev_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (any_act),
        .count   (since_any_act)
    );

    sbt_elapsed #(.CNT_W(CNT_W)) u_dev_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (any_pre),
        .count   (since_any_pre)
    );

    // R6
    dev_act_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_act |=> (since_any_act == CNT_W'(1)));

    // R7
    dev_pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pre |=> (since_any_pre == CNT_W'(1)));

endmodule

// File: rtl/sbt_bank_guard.sv
module sbt_bank_guard
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 32,
    parameter int CNT_W     = 6,
    parameter int T_RC      = 28,
    parameter int T_RAS     = 20,
    parameter int T_RP      = 8,
    parameter int T_RR      = 8,
    parameter int T_PP      = 8,
    parameter int T_RCD     = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_kind,
    input  logic [4:0] cmd_bank,
    output logic       err_adjacent,
    output logic       err_act_act_bank,
    output logic       err_act_pre,
    output logic       err_pre_act,
    output logic       err_act_act_dev,
    output logic       err_pre_pre_dev,
    output logic       err_act_col,
    output logic       err_idle_pre
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int HALF   = NUM_BANKS / 2;
    localparam logic [CNT_W-1:0] LIM_RC  = CNT_W'(T_RC);
    localparam logic [CNT_W-1:0] LIM_RAS = CNT_W'(T_RAS);
    localparam logic [CNT_W-1:0] LIM_RP  = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0] LIM_RR  = CNT_W'(T_RR);
    localparam logic [CNT_W-1:0] LIM_PP  = CNT_W'(T_PP);
    localparam logic [CNT_W-1:0] LIM_RCD = CNT_W'(T_RCD);

    cmd_kind_e         kind;
    logic              is_act, is_pre, is_col;
    logic [BANK_W-1:0] bank_idx;

    logic [NUM_BANKS-1:0] act_hit, pre_hit, bank_open, lo_busy, hi_busy;
    logic [CNT_W-1:0]     since_act [NUM_BANKS];
    logic [CNT_W-1:0]     since_pre [NUM_BANKS];
    logic [CNT_W-1:0]     dev_since_act, dev_since_pre;

    logic                 sel_open, sel_nbr_busy;
    logic [CNT_W-1:0]     sel_since_act, sel_since_pre;

    flag_set_t flag_d, flag_q;

    assign kind     = cmd_kind_e'(cmd_kind);
    assign bank_idx = cmd_bank[BANK_W-1:0];
    assign is_act   = cmd_valid && (kind == CMD_ACT);
    assign is_pre   = cmd_valid && (kind == CMD_PRE);
    assign is_col   = cmd_valid && (kind == CMD_COL);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign act_hit[b] = is_act && (bank_idx == BANK_W'(b));
        assign pre_hit[b] = is_pre && (bank_idx == BANK_W'(b));

        sbt_bank_slot #(.CNT_W(CNT_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_hit   (act_hit[b]),
            .pre_hit   (pre_hit[b]),
            .is_open   (bank_open[b]),
            .since_act (since_act[b]),
            .since_pre (since_pre[b])
        );

        if (b % HALF != 0) begin : g_lo
            assign lo_busy[b] = bank_open[b-1];
        end else begin : g_lo_edge
            assign lo_busy[b] = 1'b0;
        end

        if (b % HALF != HALF - 1) begin : g_hi
            assign hi_busy[b] = bank_open[b+1];
        end else begin : g_hi_edge
            assign hi_busy[b] = 1'b0;
        end
    end

    sbt_device_pacer #(.CNT_W(CNT_W)) u_pacer (
        .clk           (clk),
        .rst_n         (rst_n),
        .any_act       (is_act),
        .any_pre       (is_pre),
        .since_any_act (dev_since_act),
        .since_any_pre (dev_since_pre)
    );

    assign sel_open      = bank_open[bank_idx];
    assign sel_nbr_busy  = lo_busy[bank_idx] | hi_busy[bank_idx];
    assign sel_since_act = since_act[bank_idx];
    assign sel_since_pre = since_pre[bank_idx];

    always_comb begin
        flag_d              = '0;
        flag_d.adjacent     = is_act && sel_nbr_busy;
        flag_d.act_act_bank = is_act && (sel_since_act < LIM_RC);
        flag_d.act_pre      = is_pre && sel_open && (sel_since_act < LIM_RAS);
        flag_d.pre_act      = is_act && !sel_open && (sel_since_pre < LIM_RP);
        flag_d.act_act_dev  = is_act && (dev_since_act < LIM_RR);
        flag_d.pre_pre_dev  = is_pre && (dev_since_pre < LIM_PP);
        flag_d.act_col      = is_col && sel_open && (sel_since_act < LIM_RCD);
        flag_d.idle_pre     = is_pre && !sel_open;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign err_adjacent     = flag_q.adjacent;
    assign err_act_act_bank = flag_q.act_act_bank;
    assign err_act_pre      = flag_q.act_pre;
    assign err_pre_act      = flag_q.pre_act;
    assign err_act_act_dev  = flag_q.act_act_dev;
    assign err_pre_pre_dev  = flag_q.pre_pre_dev;
    assign err_act_col      = flag_q.act_col;
    assign err_idle_pre     = flag_q.idle_pre;

    // R2
    adjacent_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_act |=> !err_adjacent);

    // R11
    quiet_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (flag_q == '0));

    // R9
    idle_pre_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_idle_pre |-> (!err_act_pre && !err_act_col && !err_adjacent));

    // R7
    pre_spacing_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pre_pre_dev |-> $past(is_pre));

endmodule

// File: tb/sbt_bank_guard_test.sv
module sbt_bank_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_kind = 2'd0;
    logic [4:0] cmd_bank = 5'd0;
    logic       err_adjacent, err_act_act_bank, err_act_pre, err_pre_act;
    logic       err_act_act_dev, err_pre_pre_dev, err_act_col, err_idle_pre;
    logic [7:0] flags;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [1:0] K_ACT = 2'd1;
    localparam logic [1:0] K_PRE = 2'd2;
    localparam logic [1:0] K_COL = 2'd3;

    localparam logic [7:0] F_ADJ  = 8'h80;
    localparam logic [7:0] F_RC   = 8'h40;
    localparam logic [7:0] F_RAS  = 8'h20;
    localparam logic [7:0] F_RP   = 8'h10;
    localparam logic [7:0] F_RR   = 8'h08;
    localparam logic [7:0] F_PP   = 8'h04;
    localparam logic [7:0] F_RCD  = 8'h02;
    localparam logic [7:0] F_WARN = 8'h01;

    always #4 clk = ~clk;

    sbt_bank_guard uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_valid        (cmd_valid),
        .cmd_kind         (cmd_kind),
        .cmd_bank         (cmd_bank),
        .err_adjacent     (err_adjacent),
        .err_act_act_bank (err_act_act_bank),
        .err_act_pre      (err_act_pre),
        .err_pre_act      (err_pre_act),
        .err_act_act_dev  (err_act_act_dev),
        .err_pre_pre_dev  (err_pre_pre_dev),
        .err_act_col      (err_act_col),
        .err_idle_pre     (err_idle_pre)
    );

    assign flags = {err_adjacent, err_act_act_bank, err_act_pre, err_pre_act,
                    err_act_act_dev, err_pre_pre_dev, err_act_col, err_idle_pre};

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_kind = 2'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] k, input int b, output logic [7:0] f);
        cmd_valid = 1'b1;
        cmd_kind = k;
        cmd_bank = 5'(b);
        @(negedge clk);
        f = flags;
        cmd_valid = 1'b0;
        cmd_kind = 2'd0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] f;
        logic [7:0] e;

        // R1: reset state and first activate
        do_reset();
        @(negedge clk);
        check("R1 reset flags", flags, 8'h00);
        issue(K_ACT, 5, f);
        check("R1 first activate", f, 8'h00);

        // R3 / R6: same-bank activate spacing sweep
        for (int d = 1; d <= 32; d++) begin
            do_reset();
            issue(K_ACT, 3, f);
            gap(d - 1);
            issue(K_ACT, 3, f);
            e = 8'h00;
            if (d < 28) e |= F_RC;
            if (d < 8)  e |= F_RR;
            check("R3/R6 reactivate", f, e);
        end

        // R11: flag is a single-cycle pulse
        do_reset();
        issue(K_ACT, 3, f);
        issue(K_ACT, 3, f);
        check("R11 pulse raised", f, F_RC | F_RR);
        @(negedge clk);
        check("R11 pulse cleared", flags, 8'h00);

        // R4: activate-to-precharge sweep
        for (int d = 1; d <= 24; d++) begin
            do_reset();
            issue(K_ACT, 7, f);
            gap(d - 1);
            issue(K_PRE, 7, f);
            check("R4 act to pre", f, (d < 20) ? F_RAS : 8'h00);
        end

        // R5: precharge-to-activate sweep
        for (int d = 1; d <= 12; d++) begin
            do_reset();
            issue(K_ACT, 9, f);
            gap(29);
            issue(K_PRE, 9, f);
            gap(d - 1);
            issue(K_ACT, 9, f);
            check("R5 pre to act", f, (d < 8) ? F_RP : 8'h00);
        end

        // R7: device precharge spacing sweep
        for (int d = 1; d <= 12; d++) begin
            do_reset();
            issue(K_ACT, 2, f);
            gap(9);
            issue(K_ACT, 20, f);
            gap(24);
            issue(K_PRE, 2, f);
            gap(d - 1);
            issue(K_PRE, 20, f);
            check("R7 pre spacing", f, (d < 8) ? F_PP : 8'h00);
        end

        // R8: activate-to-column sweep
        for (int d = 1; d <= 12; d++) begin
            do_reset();
            issue(K_ACT, 11, f);
            gap(d - 1);
            issue(K_COL, 11, f);
            check("R8 act to col", f, (d < 9) ? F_RCD : 8'h00);
        end
        issue(K_COL, 12, f);
        check("R8 col to closed bank", f, 8'h00);

        // R2: both neighbours of every bank
        for (int a = 0; a < 32; a++) begin
            for (int s = -1; s <= 1; s += 2) begin
                int nb;
                nb = a + s;
                if (nb >= 0 && nb < 32) begin
                    do_reset();
                    issue(K_ACT, nb, f);
                    gap(9);
                    issue(K_ACT, a, f);
                    check("R2 neighbour", f, ((a / 16) == (nb / 16)) ? F_ADJ : 8'h00);
                end
            end
        end

        // R2 / R6 together in one cycle
        do_reset();
        issue(K_ACT, 9, f);
        gap(2);
        issue(K_ACT, 8, f);
        check("R2/R6 same cycle", f, F_ADJ | F_RR);

        // R9: precharge to closed bank
        do_reset();
        issue(K_PRE, 4, f);
        check("R9 idle precharge warning", f, F_WARN);
        gap(9);
        issue(K_ACT, 4, f);
        check("R9 no precharge timer restart", f, 8'h00);
        gap(9);
        issue(K_ACT, 5, f);
        check("R9 bank opened by later act", f, F_ADJ);

        // R10: saturation across a long gap
        do_reset();
        issue(K_ACT, 6, f);
        gap(200);
        issue(K_ACT, 6, f);
        check("R10 long gap reactivate", f, 8'h00);
        gap(200);
        issue(K_PRE, 6, f);
        check("R10 long gap precharge", f, 8'h00);

        // R11: invalid cycle is ignored
        do_reset();
        issue(K_ACT, 5, f);
        gap(9);
        cmd_valid = 1'b0;
        cmd_kind = K_ACT;
        cmd_bank = 5'd6;
        @(negedge clk);
        check("R11 invalid cycle flags", flags, 8'h00);
        cmd_kind = 2'd0;
        gap(8);
        issue(K_ACT, 7, f);
        check("R11 invalid act left bank closed", f, 8'h00);

        finish_run();
    end
endmodule